// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Single-Frame Holding Buffer

This block recovers characters from an idle-high asynchronous serial line. A 16x oversampling tick paces it. When the line falls, the receiver waits half a bit period and checks that the line is still low. If it is, the receiver takes each following bit at the middle of its bit cell and shifts it into a shift register, least significant bit first. An optional parity bit follows the data. The receiver samples the first stop bit. On that same tick the assembled word moves into a holding buffer and a receive-complete flag is raised. The receiver does not wait for or check any second stop bit, so it can accept a start edge half a bit into a two-stop gap.

A host configures the data width (5 to 9 bits), parity enable and parity sense, and then holds them steady. It waits for the receive-complete flag, takes the character from the data outputs and pulses the read strobe, which lowers the flag. A receive enable hands the pin to the block: while the enable is low the block stays idle and reports that it does not own the line.

Top module: `uart_frame_rx`

Controller states are `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_PARITY` and `RX_STOP`. The transitions are:
- `RX_IDLE` to `RX_START` on a tick that sees the line low.
- `RX_START` to `RX_IDLE` when the line is high at the half-bit check, or to `RX_DATA` when it is still low.
- `RX_DATA` to `RX_DATA` after each data bit.
- `RX_DATA` to `RX_PARITY` or `RX_STOP` after the last data bit, depending on parity enable.
- `RX_PARITY` to `RX_STOP` after the parity sample.
- `RX_STOP` to `RX_IDLE` at the stop sample, which is also the commit.
- Any state to `RX_IDLE` whenever the enable is low.

## Requirements
- R1: A start is accepted only if the line is still low at the 8th tick after the tick that first saw it low. A shorter low pulse returns the receiver to idle and produces no frame.
- R2: Data bits are sampled every 16 ticks at mid-cell, least significant bit first. The count comes from `data_bits_i` (5 to 9). A value below 5 acts as 5, and a value above 9 acts as 9.
- R3: The frame commits at the first stop-bit sample and any second stop bit is ignored. A new start bit that directly follows a single stop bit is received correctly.
- R4: `rx_done_o` is high one clock after a commit. `rd_data_o`, `rd_bit8_o` and the error outputs then hold steady until the next commit.
- R5: A one-cycle `rd_i` pulse lowers `rx_done_o` on the next clock, unless a commit happens in the same cycle.
- R6: For frames shorter than 8 bits, the unused upper bits of `rd_data_o` are zero. `rd_bit8_o` carries the 9th data bit in 9-bit frames and is 0 otherwise.
- R7: When `parity_en_i` is 1, one parity bit follows the data. It is even parity when `parity_odd_i` is 0 and odd parity when it is 1. A wrong parity bit gives `parity_err_o` = 1 with that frame, and `parity_err_o` = 0 otherwise.
- R8: A stop bit sampled low gives `frame_err_o` = 1 with that frame. A high stop bit gives `frame_err_o` = 0.
- R9: While `rx_en_i` is 0, the receiver returns to idle within one clock and commits nothing. `pin_own_o` equals `rx_en_i` delayed by one clock.
- R10: A frame that arrives while the buffer is still unread replaces the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_en_i | input | 1 | Receive enable |
| data_bits_i | input | 4 | Data bits per frame, 5 to 9 |
| parity_en_i | input | 1 | Parity bit present |
| parity_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_i | input | 1 | Read strobe, lowers the receive-complete flag |
| rd_data_o | output | 8 | Received character, low 8 bits |
| rd_bit8_o | output | 1 | Ninth data bit |
| rx_done_o | output | 1 | Receive-complete flag: unread data present |
| frame_err_o | output | 1 | Stop bit of the buffered frame was low |
| parity_err_o | output | 1 | Parity of the buffered frame was wrong |
| pin_own_o | output | 1 | Receiver owns the serial pin |

## Verification
If the tick counter slips by even one position, sampling moves away from mid-cell. Under random widths and values this shows up within a few frames as a shifted or corrupted character, or as a false framing error on the first frame. If the bit index stops short or runs long, the character is misaligned at the very next commit. The missing upper zeros then appear on `rd_data_o`, and `rx_done_o` comes a bit early or late. If the controller is stuck outside idle, or waits for a second stop bit, then the frame sent directly after a single stop bit is lost and `rx_done_o` never rises for it. If the flag logic is wrong, `rx_done_o` stays high one clock after a read strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int MAX_BITS = 9,
    localparam int CNT_W   = $clog2(OSR),
    localparam int BIT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                rx,
    input  logic                tick,
    input  logic [BIT_W-1:0]    nbits,
    input  logic                par_en,
    input  logic                par_odd,
    output logic                commit,
    output logic                stop_low,
    output logic                par_bad,
    output logic [MAX_BITS-1:0] shift_word,
    output logic                busy
);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    rx_state_t            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [BIT_W-1:0]     idx_q;
    logic [MAX_BITS-1:0]  shift_q;
    logic                 par_acc_q;
    logic                 par_bad_q;
    logic                 mid_hit, cell_end, last_bit;

    assign mid_hit  = tick && (cnt_q == MID_CNT);
    assign cell_end = tick && (cnt_q == LAST_CNT);
    assign last_bit = (idx_q == nbits - BIT_W'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick && !rx) state_d = RX_START;
            RX_START:  if (mid_hit)     state_d = rx ? RX_IDLE : RX_DATA;
            RX_DATA:   if (cell_end && last_bit)
                           state_d = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (cell_end)    state_d = RX_STOP;
            RX_STOP:   if (cell_end)    state_d = RX_IDLE;
            default:                    state_d = RX_IDLE;
        endcase
        if (!enable) state_d = RX_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            par_acc_q <= 1'b0;
            par_bad_q <= 1'b0;
        end else begin
            if (state_q != state_d)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + CNT_W'(1);

            if (state_q == RX_START && state_d == RX_DATA) begin
                idx_q     <= '0;
                par_acc_q <= par_odd;
                par_bad_q <= 1'b0;
            end else if (state_q == RX_DATA && cell_end) begin
                shift_q   <= {rx, shift_q[MAX_BITS-1:1]};
                par_acc_q <= par_acc_q ^ rx;
                idx_q     <= idx_q + BIT_W'(1);
            end else if (state_q == RX_PARITY && cell_end) begin
                par_bad_q <= par_acc_q ^ rx;
            end
        end
    end

    // outputs
    always_comb begin
        commit     = enable && (state_q == RX_STOP) && cell_end;
        stop_low   = !rx;
        par_bad    = par_en && par_bad_q;
        shift_word = shift_q;
        busy       = (state_q != RX_IDLE);
    end
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer #(
    parameter int MAX_BITS = 9,
    localparam int DATA_W  = MAX_BITS - 1,
    localparam int BIT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  logic [MAX_BITS-1:0] shift_word,
    input  logic [BIT_W-1:0]    nbits,
    input  logic                stop_low,
    input  logic                par_bad,
    input  logic                rd,
    output logic [DATA_W-1:0]   data,
    output logic                bit8,
    output logic                full,
    output logic                ferr,
    output logic                perr
);
    logic [MAX_BITS-1:0] aligned;

    // the newest bit enters at the top, so a short frame sits high in the word
    assign aligned = shift_word >> (BIT_W'(MAX_BITS) - nbits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            bit8 <= 1'b0;
            full <= 1'b0;
            ferr <= 1'b0;
            perr <= 1'b0;
        end else if (commit) begin
            data <= aligned[DATA_W-1:0];
            bit8 <= aligned[MAX_BITS-1];
            full <= 1'b1;
            ferr <= stop_low;
            perr <= par_bad;
        end else if (rd) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
    parameter int OSR         = 16,
    parameter int MIN_BITS    = 5,
    parameter int MAX_BITS    = 9,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W     = MAX_BITS - 1,
    localparam int BIT_W      = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick_i,
    input  logic              rx_en_i,
    input  logic [3:0]        data_bits_i,
    input  logic              parity_en_i,
    input  logic              parity_odd_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_bit8_o,
    output logic              rx_done_o,
    output logic              frame_err_o,
    output logic              parity_err_o,
    output logic              pin_own_o
);
    logic                rx_s;
    logic                commit;
    logic                stop_low;
    logic                par_bad;
    logic                rx_busy;
    logic [MAX_BITS-1:0] shift_word;
    logic [BIT_W-1:0]    nbits;

    always_comb begin
        if (int'(data_bits_i) < MIN_BITS)      nbits = BIT_W'(MIN_BITS);
        else if (int'(data_bits_i) > MAX_BITS) nbits = BIT_W'(MAX_BITS);
        else                                   nbits = BIT_W'(data_bits_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_own_o <= 1'b0;
        else        pin_own_o <= rx_en_i;
    end

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_i),
        .dout (rx_s)
    );

    uart_rx_fsm #(.OSR(OSR), .MAX_BITS(MAX_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_en_i),
        .rx        (rx_s),
        .tick      (tick_i),
        .nbits     (nbits),
        .par_en    (parity_en_i),
        .par_odd   (parity_odd_i),
        .commit    (commit),
        .stop_low  (stop_low),
        .par_bad   (par_bad),
        .shift_word(shift_word),
        .busy      (rx_busy)
    );

    uart_rx_buffer #(.MAX_BITS(MAX_BITS)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .shift_word(shift_word),
        .nbits     (nbits),
        .stop_low  (stop_low),
        .par_bad   (par_bad),
        .rd        (rd_i),
        .data      (rd_data_o),
        .bit8      (rd_bit8_o),
        .full      (rx_done_o),
        .ferr      (frame_err_o),
        .perr      (parity_err_o)
    );
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en_i,
    input logic              rd_i,
    input logic              commit,
    input logic              rx_busy,
    input logic              rx_done_o,
    input logic              pin_own_o,
    input logic [DATA_W-1:0] rd_data_o
);
    a_r9_pin_taken: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_i |=> pin_own_o);

    a_r9_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !pin_own_o);

    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !rx_busy);

    a_r4_commit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> rx_done_o);

    a_r4_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rd_data_o));

    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !commit) |=> !rx_done_o);
endmodule

bind uart_frame_rx uart_frame_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en_i  (rx_en_i),
    .rd_i     (rd_i),
    .commit   (commit),
    .rx_busy  (rx_busy),
    .rx_done_o(rx_done_o),
    .pin_own_o(pin_own_o),
    .rd_data_o(rd_data_o)
);

// File: tb/tb_uart_frame_rx.sv
module tb_uart_frame_rx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       rx_en_i = 1'b0;
    logic [3:0] data_bits_i = 4'd8;
    logic       parity_en_i = 1'b0;
    logic       parity_odd_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] rd_data_o;
    logic       rd_bit8_o, rx_done_o, frame_err_o, parity_err_o, pin_own_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int tdiv     = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_i <= (tdiv == TICK_DIV - 1);
    end

    uart_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
        .rx_en_i(rx_en_i), .data_bits_i(data_bits_i),
        .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
        .rd_i(rd_i), .rd_data_o(rd_data_o), .rd_bit8_o(rd_bit8_o),
        .rx_done_o(rx_done_o), .frame_err_o(frame_err_o),
        .parity_err_o(parity_err_o), .pin_own_o(pin_own_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_bits(input int n);
        return (n < 5) ? 5 : (n > 9) ? 9 : n;
    endfunction

    function automatic logic [8:0] masked(input logic [8:0] d, input int n);
        return d & 9'((1 << eff_bits(n)) - 1);
    endfunction

    function automatic logic par_of(input logic [8:0] d, input int n, input logic odd);
        return (^masked(d, n)) ^ odd;
    endfunction

    task automatic hold_bit(input logic lvl);
        rx_i = lvl;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int n, input bit pen, input bit podd,
                        input bit flip_par, input logic stop_lvl, input int nstop);
        hold_bit(1'b0);
        for (int i = 0; i < eff_bits(n); i++) hold_bit(d[i]);
        if (pen) hold_bit(par_of(d, n, podd) ^ flip_par);
        hold_bit(stop_lvl);
        for (int i = 1; i < nstop; i++) hold_bit(1'b1);
        rx_i = 1'b1;
    endtask

    task automatic do_read();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        check(rx_done_o == 1'b0, "R5 flag clears after read", int'(rx_done_o), 0);
    endtask

    task automatic expect_frame(input string req, input logic [8:0] d, input int n,
                                input bit perr, input bit ferr);
        logic [8:0] e;
        e = masked(d, n);
        check(rx_done_o == 1'b1, {req, " flag set"}, int'(rx_done_o), 1);
        check({rd_bit8_o, rd_data_o} == e, {req, " data"}, int'({rd_bit8_o, rd_data_o}), int'(e));
        check(parity_err_o == perr, {req, " parity flag"}, int'(parity_err_o), int'(perr));
        check(frame_err_o == ferr, {req, " framing flag"}, int'(frame_err_o), int'(ferr));
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [8:0] d1, d2;
        int n;
        bit pen, podd;
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        check(rx_done_o == 0 && pin_own_o == 0 && rd_data_o == 0, "R4 reset state",
              int'({rx_done_o, pin_own_o, rd_data_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rx_en_i = 1'b1;
        @(negedge clk); @(negedge clk);
        check(pin_own_o == 1'b1, "R9 pin owned", int'(pin_own_o), 1);
        hold_bit(1'b1);

        // R2 plain 8-bit frame
        send(9'h0A5, 8, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R2 8-bit", 9'h0A5, 8, 0, 0);
        do_read();

        // R1 short low pulse must not start a frame
        rx_i = 1'b0; repeat (4 * TICK_DIV) @(negedge clk); rx_i = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check(rx_done_o == 1'b0, "R1 glitch rejected", int'(rx_done_o), 0);
        send(9'h03C, 8, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R1 frame after glitch", 9'h03C, 8, 0, 0);
        do_read();

        // R6 5-bit frame with upper bits set in source, 9-bit frame
        data_bits_i = 4'd5;
        send(9'h1FF, 5, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R6 5-bit zero fill", 9'h1FF, 5, 0, 0);
        do_read();
        data_bits_i = 4'd9;
        send(9'h155, 9, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R6 9-bit ninth bit", 9'h155, 9, 0, 0);
        do_read();
        data_bits_i = 4'd2;
        send(9'h0F6, 2, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R2 clamp low width", 9'h0F6, 2, 0, 0);
        do_read();

        // R7 parity good and bad
        data_bits_i = 4'd8; parity_en_i = 1'b1; parity_odd_i = 1'b1;
        send(9'h037, 8, 1, 1, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R7 odd parity ok", 9'h037, 8, 0, 0);
        do_read();
        parity_odd_i = 1'b0;
        send(9'h037, 8, 1, 0, 1, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R7 even parity bad", 9'h037, 8, 1, 0);
        do_read();
        parity_en_i = 1'b0;

        // R8 low stop bit
        send(9'h081, 8, 0, 0, 0, 1'b0, 1);
        expect_frame("R8 framing", 9'h081, 8, 0, 1);
        do_read();
        rx_en_i = 1'b0; @(negedge clk); @(negedge clk); rx_en_i = 1'b1;
        hold_bit(1'b1);

        // R3 back-to-back frames with one stop bit
        fork
            begin
                send(9'h0C3, 8, 0, 0, 0, 1'b1, 1);
                send(9'h05E, 8, 0, 0, 0, 1'b1, 1);
                hold_bit(1'b1);
            end
            begin
                while (!rx_done_o) @(negedge clk);
                expect_frame("R3 first of pair", 9'h0C3, 8, 0, 0);
                do_read();
            end
        join
        expect_frame("R3 second of pair", 9'h05E, 8, 0, 0);
        do_read();

        // R3 second stop bit ignored: flag set before it ends
        fork
            send(9'h011, 8, 0, 0, 0, 1'b1, 2);
            begin
                repeat (10 * BIT_CLKS) @(negedge clk);
                check(rx_done_o == 1'b1, "R3 commit before 2nd stop", int'(rx_done_o), 1);
            end
        join
        hold_bit(1'b1);
        do_read();

        // R10 overwrite of unread frame
        send(9'h0AA, 8, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        send(9'h044, 8, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        expect_frame("R10 newest kept", 9'h044, 8, 0, 0);
        do_read();

        // R9 disabled receiver ignores a frame
        rx_en_i = 1'b0;
        @(negedge clk); @(negedge clk);
        check(pin_own_o == 1'b0, "R9 pin released", int'(pin_own_o), 0);
        send(9'h0FF, 8, 0, 0, 0, 1'b1, 1); hold_bit(1'b1);
        check(rx_done_o == 1'b0, "R9 no frame while off", int'(rx_done_o), 0);
        rx_en_i = 1'b1;
        hold_bit(1'b1);

        // random frames
        for (int k = 0; k < 30; k++) begin
            d1   = 9'($urandom);
            n    = 5 + int'($urandom % 5);
            pen  = bit'($urandom % 2);
            podd = bit'($urandom % 2);
            data_bits_i  = 4'(n);
            parity_en_i  = pen;
            parity_odd_i = podd;
            d2 = 9'(k);
            send(d1, n, pen, podd, d2[2] & pen, 1'b1, 1 + int'($urandom % 2));
            hold_bit(1'b1);
            expect_frame("R2 random", d1, n, d2[2] & pen, 0);
            do_read();
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule